// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker

This block sits between the frame buffer fetch path and a TFT panel timing stage. It takes 32-bit words read from memory, one per valid/ready handshake, and produces 24-bit RGB pixels on a second valid/ready port. Depending on the colour depth selected in a control word, a single input word holds either one pixel or two.

Four direct-colour layouts are decoded: a 24-bit pixel in a 32-bit container and three 16-bit layouts (5:5:5, 5:6:5 and 4:4:4). By default the red channel sits in the least-significant bits of a pixel, green above it and blue at the top. A single control bit exchanges the red and blue positions. Channels narrower than eight bits are widened by copying their upper bits into the vacated low bits, so full scale maps to 0xFF. The palette depths are not decoded here: they yield black pixels at one pixel per word, so the fetch path never stalls on them. The control word also carries a TFT-select bit and a panel power bit; the latter is brought out as a registered pin.

The control word is treated as static while words are in flight; software changes it only when the pipeline is empty.

Top module: `fb_unpacker`

## Requirements
- R1: While reset is high and in the first cycle after it, `pix_vld_o` is 0, `word_rdy_o` is 1 and `panel_pwr_o` is 0.
- R2: Pixels leave as {red[23:16], green[15:8], blue[7:0]}. Depth code 5 (ctrl bits [3:1] = 5) decodes one pixel per word with red = word[7:0], green = word[15:8], blue = word[23:16]; word[31:24] has no effect on the pixel.
- R3: Depth code 4 takes a halfword as red [4:0], green [9:5], blue [14:10]; bit 15 has no effect; each 5-bit field v becomes (v<<3)|(v>>2).
- R4: Depth code 6 takes a halfword as red [4:0], green [10:5] (6 bits, widened to (v<<2)|(v>>4)), blue [15:11]; 5-bit fields widen as in R3.
- R5: Depth code 7 takes a halfword as red [3:0], green [7:4], blue [11:8], each widened to v*17; bits [15:12] have no effect.
- R6: In depth codes 4, 6 and 7 every word yields exactly two pixels, the one from word[15:0] first and the one from word[31:16] second.
- R7: When ctrl bit 8 is 1 the fields decoded as red and as blue in R2 to R5 swap places; green is unchanged.
- R8: Depth codes 0 to 3 yield exactly one pixel per word, of value 0.
- R9: When ctrl bit 5 (TFT select) is 0 every pixel is 0, while the pixel count per word still follows the depth code.
- R10: `panel_pwr_o` equals ctrl bit 11 as sampled at the previous clock edge.
- R11: A pixel offered with `pix_rdy_i` low stays offered, unchanged, until it is accepted; no pixel is lost or repeated under backpressure on either port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | CTRL_W (16) | Control word: depth code, red/blue swap, TFT select, panel power |
| word_vld_i | input | 1 | Input word valid |
| word_rdy_o | output | 1 | Block can take an input word |
| word_i | input | DATA_W (32) | Frame buffer word |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_rdy_i | input | 1 | Downstream takes the pixel |
| pix_o | output | 3*CHAN_W (24) | Pixel, red in the top byte |
| panel_pwr_o | output | 1 | Registered panel power enable |

## Verification
The bench builds the block with its default 32-bit word and 8-bit channels, which is small enough to sweep every depth code against both red/blue orders, and the TFT-off case for a 16-bit and the 24-bit layout. Each configuration streams a pseudo-random sequence of words, so every field of every layout sees many values including the extremes, while periodic gaps on the word side and stalls on the pixel side exercise the two-pixel-per-word hand-off under backpressure. Expected pixels come from field extraction by division and remainder in the bench.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

  localparam int CHAN_W = 8;

  typedef enum logic [2:0] {
    DEPTH_PAL1  = 3'd0,
    DEPTH_PAL2  = 3'd1,
    DEPTH_PAL4  = 3'd2,
    DEPTH_PAL8  = 3'd3,
    DEPTH_555   = 3'd4,
    DEPTH_888   = 3'd5,
    DEPTH_565   = 3'd6,
    DEPTH_444   = 3'd7
  } depth_e;

  typedef struct packed {
    logic [CHAN_W-1:0] r;
    logic [CHAN_W-1:0] g;
    logic [CHAN_W-1:0] b;
  } rgb_t;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic packs_two(input depth_e d);
    return (d == DEPTH_555) || (d == DEPTH_565) || (d == DEPTH_444);
  endfunction

endpackage

// File: rtl/fbu_decode.sv
module fbu_decode
  import fbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              upper_i,
  input  depth_e            depth_i,
  input  logic              swap_i,
  input  logic              tft_i,
  output logic              two_px_o,
  output rgb_t              pix_o
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] half;
  logic [7:0]        lo_c, mid_c, hi_c;

  assign half = upper_i ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];

  always_comb begin
    lo_c  = '0;
    mid_c = '0;
    hi_c  = '0;
    unique case (depth_i)
      DEPTH_555: begin
        lo_c  = widen5(half[4:0]);
        mid_c = widen5(half[9:5]);
        hi_c  = widen5(half[14:10]);
      end
      DEPTH_565: begin
        lo_c  = widen5(half[4:0]);
        mid_c = widen6(half[10:5]);
        hi_c  = widen5(half[15:11]);
      end
      DEPTH_444: begin
        lo_c  = widen4(half[3:0]);
        mid_c = widen4(half[7:4]);
        hi_c  = widen4(half[11:8]);
      end
      DEPTH_888: begin
        lo_c  = word_i[7:0];
        mid_c = word_i[15:8];
        hi_c  = word_i[23:16];
      end
      default: begin
        lo_c  = '0;
        mid_c = '0;
        hi_c  = '0;
      end
    endcase
  end

  assign two_px_o = packs_two(depth_i);

  always_comb begin
    if (!tft_i) begin
      pix_o = '0;
    end else begin
      pix_o.g = mid_c;
      pix_o.r = swap_i ? hi_c : lo_c;
      pix_o.b = swap_i ? lo_c : hi_c;
    end
  end

endmodule

// File: rtl/fbu_seq.sv
module fbu_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              word_rdy_o,
  input  logic              adv_i,
  input  logic              two_px_i,
  output logic              load_o,
  output logic              upper_o,
  output logic [DATA_W-1:0] word_o
);

  logic              held_q;
  logic              upper_q;
  logic [DATA_W-1:0] word_q;
  logic              last;

  assign last       = !two_px_i || upper_q;
  assign load_o     = held_q && adv_i;
  assign word_rdy_o = !held_q || (adv_i && last);
  assign upper_o    = upper_q;
  assign word_o     = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      upper_q <= 1'b0;
      word_q  <= '0;
    end else begin
      if (load_o) begin
        if (last) begin
          held_q  <= 1'b0;
          upper_q <= 1'b0;
        end else begin
          upper_q <= 1'b1;
        end
      end
      if (word_vld_i && word_rdy_o) begin
        word_q  <= word_i;
        held_q  <= 1'b1;
        upper_q <= 1'b0;
      end
    end
  end

  // R6
  upper_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    upper_q |-> held_q);

  // R11
  held_word_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (held_q && !adv_i) |=> (held_q && $stable(word_q)));

endmodule

// File: rtl/fbu_outreg.sv
module fbu_outreg #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             rdy_i,
  output logic             adv_o,
  output logic             vld_o,
  output logic [PIX_W-1:0] pix_o
);

  logic             vld_q;
  logic [PIX_W-1:0] pix_q;

  assign adv_o = !vld_q || rdy_i;
  assign vld_o = vld_q;
  assign pix_o = pix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      pix_q <= '0;
    end else if (adv_o) begin
      vld_q <= load_i;
      if (load_i) pix_q <= pix_i;
    end
  end

  // R11
  stalled_pixel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !rdy_i) |=> (vld_q && $stable(pix_q)));

endmodule

// File: rtl/fb_unpacker.sv
module fb_unpacker
  import fbu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CTRL_W   = 16,
  parameter int BPP_LSB  = 1,
  parameter int SWAP_BIT = 8,
  parameter int TFT_BIT  = 5,
  parameter int PWR_BIT  = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic                word_vld_i,
  output logic                word_rdy_o,
  input  logic [DATA_W-1:0]   word_i,
  output logic                pix_vld_o,
  input  logic                pix_rdy_i,
  output logic [3*CHAN_W-1:0] pix_o,
  output logic                panel_pwr_o
);

  localparam int PIX_W = 3 * CHAN_W;

  depth_e            depth;
  logic              adv, load, upper, two_px;
  logic [DATA_W-1:0] word_held;
  rgb_t              pix_dec;
  logic              pwr_q;

  assign depth = depth_e'(ctrl_i[BPP_LSB +: 3]);

  fbu_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .word_vld_i(word_vld_i),
    .word_i    (word_i),
    .word_rdy_o(word_rdy_o),
    .adv_i     (adv),
    .two_px_i  (two_px),
    .load_o    (load),
    .upper_o   (upper),
    .word_o    (word_held)
  );

  fbu_decode #(.DATA_W(DATA_W)) u_dec (
    .word_i  (word_held),
    .upper_i (upper),
    .depth_i (depth),
    .swap_i  (ctrl_i[SWAP_BIT]),
    .tft_i   (ctrl_i[TFT_BIT]),
    .two_px_o(two_px),
    .pix_o   (pix_dec)
  );

  fbu_outreg #(.PIX_W(PIX_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .pix_i (pix_dec),
    .rdy_i (pix_rdy_i),
    .adv_o (adv),
    .vld_o (pix_vld_o),
    .pix_o (pix_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pwr_q <= 1'b0;
    else     pwr_q <= ctrl_i[PWR_BIT];
  end
  assign panel_pwr_o = pwr_q;

  // R10
  panel_pwr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (panel_pwr_o == $past(ctrl_i[PWR_BIT])));

endmodule

// File: tb/fb_unpacker_tb.sv
module fb_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl = '0;
  logic        word_vld = 1'b0;
  logic        word_rdy;
  logic [31:0] word = '0;
  logic        pix_vld;
  logic        pix_rdy = 1'b0;
  logic [23:0] pix;
  logic        panel_pwr;

  int checks = 0;
  int fails  = 0;

  logic [23:0] exp_q [0:127];
  string       tag_q [0:127];
  int wp, rp;

  always #10 clk = ~clk;

  fb_unpacker u_dut (
    .clk(clk), .rst(rst), .ctrl_i(ctrl),
    .word_vld_i(word_vld), .word_rdy_o(word_rdy), .word_i(word),
    .pix_vld_o(pix_vld), .pix_rdy_i(pix_rdy), .pix_o(pix),
    .panel_pwr_o(panel_pwr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int unsigned wid(input int unsigned v, input int unsigned bits);
    int unsigned maxv = (1 << bits) - 1;
    if (bits == 4) return v * 17;
    return v * (256 / (maxv + 1)) + v / (1 << (2 * bits - 8));
  endfunction

  function automatic logic [23:0] model(input logic [31:0] w, input bit hi,
                                        input int bpp, input bit sw, input bit tft);
    int unsigned h = hi ? (w / 65536) : (w % 65536);
    int unsigned a, g, c;
    case (bpp)
      4: begin a = wid(h % 32, 5); g = wid((h / 32) % 32, 5); c = wid((h / 1024) % 32, 5); end
      6: begin a = wid(h % 32, 5); g = wid((h / 32) % 64, 6); c = wid((h / 2048) % 32, 5); end
      7: begin a = wid(h % 16, 4); g = wid((h / 16) % 16, 4); c = wid((h / 256) % 16, 4); end
      5: begin a = w % 256; g = (w / 256) % 256; c = (w / 65536) % 256; end
      default: begin a = 0; g = 0; c = 0; end
    endcase
    if (!tft) begin a = 0; g = 0; c = 0; end
    if (sw) return 24'(c * 65536 + g * 256 + a);
    return 24'(a * 65536 + g * 256 + c);
  endfunction

  function automatic string req_of(input int bpp, input bit sw, input bit tft, input bit hi);
    string s;
    if (!tft) s = "R9";
    else case (bpp)
      4: s = "R3"; 5: s = "R2"; 6: s = "R4"; 7: s = "R5"; default: s = "R8";
    endcase
    if (sw) s = {s, "/R7"};
    if (hi) s = {s, "/R6"};
    return s;
  endfunction

  task automatic run_cfg(input int bpp, input bit sw, input bit tft, input bit pwr, input bit bp);
    int sent = 0, guard = 0, cyc = 0, npx;
    bit hold = 0;
    logic [23:0] held_pix = '0;
    logic [31:0] cur = 32'(bpp * 7919 + sw * 131 + 17);
    wp = 0; rp = 0;
    npx = (bpp == 4 || bpp == 6 || bpp == 7) ? 2 : 1;
    @(negedge clk);
    ctrl = 16'(((pwr ? 1 : 0) << 11) | ((sw ? 1 : 0) << 8) | ((tft ? 1 : 0) << 5) | (bpp << 1));
    @(negedge clk);
    @(negedge clk);
    // R10
    check(panel_pwr == pwr, "R10", panel_pwr, pwr);
    while ((sent < 40 || rp < wp || pix_vld) && guard < 5000) begin
      @(negedge clk);
      guard++; cyc++;
      if (hold) begin
        // R11
        check(pix_vld && pix == held_pix, "R11", pix, held_pix);
      end
      pix_rdy  = bp ? (cyc % 5 != 3) : 1'b1;
      word_vld = (sent < 40) && (!bp || cyc % 7 != 0);
      word     = cur;
      #1;
      hold     = pix_vld && !pix_rdy;
      held_pix = pix;
      if (pix_vld && pix_rdy) begin
        if (rp < wp) begin
          check(pix == exp_q[rp], tag_q[rp], pix, exp_q[rp]);
          rp++;
        end else begin
          check(1'b0, (npx == 2) ? "R6" : "R8", pix, 0);
        end
      end
      if (word_vld && word_rdy) begin
        for (int k = 0; k < npx; k++) begin
          exp_q[wp] = model(cur, k[0], bpp, sw, tft);
          tag_q[wp] = req_of(bpp, sw, tft, k[0]);
          wp++;
        end
        sent++;
        cur = cur * 32'd1103515245 + 32'd12345;
      end
    end
    word_vld = 1'b0;
    if (guard >= 5000) check(1'b0, "R11", guard, 0);
    // R6 R8: pixels per word
    check(wp == sent * npx && rp == wp, (npx == 2) ? "R6" : "R8", rp, sent * npx);
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(pix_vld == 1'b0 && word_rdy == 1'b1 && panel_pwr == 1'b0, "R1",
          {pix_vld, word_rdy, panel_pwr}, 3'b010);
    rst = 1'b0;
    @(negedge clk);
    check(pix_vld == 1'b0 && word_rdy == 1'b1 && panel_pwr == 1'b0, "R1",
          {pix_vld, word_rdy, panel_pwr}, 3'b010);
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        run_cfg(m, s[0], 1'b1, m[0] ^ s[0], (m + s) % 2 == 0);
      end
    end
    run_cfg(6, 1'b0, 1'b0, 1'b1, 1'b1);
    run_cfg(5, 1'b1, 1'b0, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule